// File: doc/BRIEF.md
# Dual-Issue Dispatcher with Floating-Point Interlock

This block is the in-order issue stage of a two-wide core. Each cycle it looks at the two oldest pre-decoded instructions offered by the front end: the older one is candidate 0 and the younger one is candidate 1. It places up to two of them into a primary and a secondary issue slot. It reports how many candidates it consumed, so that the front end can advance its queue by that amount.

Floating-point work goes to a single non-pipelined execution unit. That unit is modelled here as an occupancy counter whose load value depends on the operation class. Only the primary slot may carry a floating-point operation. An integer instruction may still ride alongside it in the secondary slot. While the unit is busy, integer instructions keep issuing at full width. A second floating-point instruction waits at the head of the stream until the unit is free. Because issue is in order, nothing behind it issues either.

The block also produces a stall flag, a unit-busy flag, a registered per-cycle issue count and two running totals. A bench can use these to compare throughput against a hand-computed schedule.

Top module: `dual_issue_dispatch`

## Requirements
- R1: Reset is asserted asynchronously and released through a two-stage synchronizer. While reset is held, and in the cycle in which the reset pin is released, `take_cnt` is 0. All registered outputs read 0 during reset. Candidates are accepted from the second clock edge after release.
- R2: Class codes are 00 integer, 01 floating-point register operation, 10 floating-point conversion, and 11 reserved. The reserved code is handled exactly as integer.
- R3: The secondary slot never carries a floating-point instruction. A floating-point candidate 1 is left unconsumed, so that it becomes candidate 0 in a later cycle.
- R4: When candidate 0 is issued and candidate 1 is a valid integer instruction, both issue in the same cycle. This holds also when candidate 0 is floating-point.
- R5: If candidate 0 is floating-point while the unit is busy, `stall` is 1 and `take_cnt` is 0. At most one floating-point operation is in flight.
- R6: A register operation occupies the unit for 3 cycles. A floating-point op issued in cycle t lets the next one issue in cycle t+3 with no stall.
- R7: A conversion occupies the unit for 6 cycles. The next floating-point op stalls 5 cycles when it is presented in the cycle right after the conversion.
- R8: Integer pairs issue two per cycle whether or not the unit is busy.
- R9: `take_cnt` (combinational) is the number of candidates consumed at the coming edge. After that edge, the slot valid and class outputs and `issue_count` show the issued instructions. An empty slot shows class 00.
- R10: `fpu_busy` is 1 exactly in the cycles in which a new floating-point op would be refused.
- R11: `total_issued` adds up every issued instruction and `fp_issued` counts every issued floating-point instruction. Both wrap modulo 2^CNT_W.
- R12: When candidate 0 is not valid, nothing issues, whatever candidate 1 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand0_valid | input | 1 | Oldest candidate present |
| cand0_class | input | 2 | Class code of oldest candidate |
| cand1_valid | input | 1 | Second candidate present |
| cand1_class | input | 2 | Class code of second candidate |
| take_cnt | output | 2 | Candidates consumed this cycle (0..2) |
| stall | output | 1 | Head is floating-point and the unit is busy |
| fpu_busy | output | 1 | Floating-point unit occupied |
| slot0_valid | output | 1 | Primary slot issued last edge |
| slot0_class | output | 2 | Class in primary slot |
| slot1_valid | output | 1 | Secondary slot issued last edge |
| slot1_class | output | 2 | Class in secondary slot |
| issue_count | output | 2 | Instructions issued last edge |
| total_issued | output | CNT_W | Running count of issued instructions |
| fp_issued | output | CNT_W | Running count of floating-point issues |

## Verification
A wrong occupancy count shows at the ports in the very cycle the next floating-point candidate appears. `stall` and `take_cnt` disagree with the arithmetic schedule there, and `fpu_busy` drops too early or too late one edge later. A pairing fault shows in `take_cnt` combinationally, and in the slot outputs after one edge. The running totals make a lost or duplicated issue visible for the rest of the run. The sweep visits every candidate pair against an idle unit, a unit busy from a register operation, and a unit busy from a conversion.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'b00,
    CLS_FPR = 2'b01,
    CLS_FCV = 2'b10,
    CLS_RSV = 2'b11
  } iclass_t;

  function automatic logic is_fp(input logic [1:0] c);
    return (c == CLS_FPR) || (c == CLS_FCV);
  endfunction
endpackage

// File: rtl/dispatch_rst_sync.sv
module dispatch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fpu_occupancy.sv
module fpu_occupancy #(
  parameter int LAT_ARITH      = 3,
  parameter int LAT_CONV_EXTRA = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_conv,
  output logic busy
);
  localparam int LAT_CONV = LAT_ARITH + LAT_CONV_EXTRA;
  localparam int BW       = (LAT_CONV > 2) ? $clog2(LAT_CONV) : 1;
  localparam logic [BW-1:0] LOAD_ARITH = BW'(LAT_ARITH - 1);
  localparam logic [BW-1:0] LOAD_CONV  = BW'(LAT_CONV - 1);

  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_d;
  logic          cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = start | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (start)     cnt_d = start_conv ? LOAD_CONV : LOAD_ARITH;
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: a start never arrives while an operation occupies the unit
  assert_single_inflight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R6: a register operation loads its full occupancy
  assert_arith_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !start_conv) |=> (cnt_q == LOAD_ARITH));

  // R7: a conversion loads the longer occupancy
  assert_conv_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_conv) |=> (cnt_q == LOAD_CONV));

  // R10: the counter drains by one per cycle while busy
  assert_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pair_select.sv
module pair_select
  import dispatch_pkg::*;
(
  input  logic       enable,
  input  logic       v0,
  input  logic [1:0] c0,
  input  logic       v1,
  input  logic [1:0] c1,
  input  logic       fpu_busy,
  output logic       issue0,
  output logic       issue1,
  output logic       fp_start,
  output logic       fp_conv,
  output logic       stall
);
  logic head_fp;
  logic second_fp;

  always_comb begin
    head_fp   = is_fp(c0);
    second_fp = is_fp(c1);
    stall     = enable && v0 && head_fp && fpu_busy;
    issue0    = enable && v0 && !stall;
    issue1    = issue0 && v1 && !second_fp;
    fp_start  = issue0 && head_fp;
    fp_conv   = fp_start && (c0 == CLS_FCV);
  end
endmodule

// File: rtl/issue_counter.sv
module issue_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   inc,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = (inc != 2'd0);

  always_comb begin
    cnt_d = cnt_q + W'(inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/dual_issue_dispatch.sv
module dual_issue_dispatch
  import dispatch_pkg::*;
#(
  parameter int LAT_ARITH      = 3,
  parameter int LAT_CONV_EXTRA = 3,
  parameter int CNT_W          = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand0_valid,
  input  logic [1:0]       cand0_class,
  input  logic             cand1_valid,
  input  logic [1:0]       cand1_class,
  output logic [1:0]       take_cnt,
  output logic             stall,
  output logic             fpu_busy,
  output logic             slot0_valid,
  output logic [1:0]       slot0_class,
  output logic             slot1_valid,
  output logic [1:0]       slot1_class,
  output logic [1:0]       issue_count,
  output logic [CNT_W-1:0] total_issued,
  output logic [CNT_W-1:0] fp_issued
);
  localparam int NCNT = 2;

  logic rst_int_n;
  logic issue0, issue1, fp_start, fp_conv;

  dispatch_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  fpu_occupancy #(
    .LAT_ARITH      (LAT_ARITH),
    .LAT_CONV_EXTRA (LAT_CONV_EXTRA)
  ) u_fpu (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (fp_start),
    .start_conv (fp_conv),
    .busy       (fpu_busy)
  );

  pair_select u_pair (
    .enable   (rst_int_n),
    .v0       (cand0_valid),
    .c0       (cand0_class),
    .v1       (cand1_valid),
    .c1       (cand1_class),
    .fpu_busy (fpu_busy),
    .issue0   (issue0),
    .issue1   (issue1),
    .fp_start (fp_start),
    .fp_conv  (fp_conv),
    .stall    (stall)
  );

  assign take_cnt = {1'b0, issue0} + {1'b0, issue1};

  // Issue slot registers
  logic       s0v_q, s1v_q, s0v_d, s1v_d;
  logic [1:0] s0c_q, s1c_q, s0c_d, s1c_d;
  logic [1:0] cnt_q, cnt_d;

  always_comb begin
    s0v_d = issue0;
    s1v_d = issue1;
    s0c_d = issue0 ? cand0_class : CLS_INT;
    s1c_d = issue1 ? cand1_class : CLS_INT;
    cnt_d = take_cnt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s0v_q <= 1'b0;
      s1v_q <= 1'b0;
      s0c_q <= CLS_INT;
      s1c_q <= CLS_INT;
      cnt_q <= 2'd0;
    end else begin
      s0v_q <= s0v_d;
      s1v_q <= s1v_d;
      s0c_q <= s0c_d;
      s1c_q <= s1c_d;
      cnt_q <= cnt_d;
    end
  end

  assign slot0_valid = s0v_q;
  assign slot1_valid = s1v_q;
  assign slot0_class = s0c_q;
  assign slot1_class = s1c_q;
  assign issue_count = cnt_q;

  // Running totals
  logic [1:0]       cnt_inc [NCNT];
  logic [CNT_W-1:0] cnt_val [NCNT];

  assign cnt_inc[0] = take_cnt;
  assign cnt_inc[1] = {1'b0, fp_start};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    issue_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .inc   (cnt_inc[g]),
      .count (cnt_val[g])
    );
  end

  assign total_issued = cnt_val[0];
  assign fp_issued    = cnt_val[1];

  // R3: the secondary slot only ever holds an integer-handled class
  assert_sec_int_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    slot1_valid |-> !is_fp(slot1_class));

  // R9: a secondary issue always comes with a primary issue
  assert_sec_needs_pri_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    slot1_valid |-> slot0_valid);

  // R5: a stalled cycle consumes nothing
  assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    stall |-> (take_cnt == 2'd0));

  // R8: integer pairs are never held back by the busy unit
  assert_int_full_width_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cand0_valid && cand1_valid && !is_fp(cand0_class) && !is_fp(cand1_class))
      |-> (take_cnt == 2'd2));

  // R11: the fp total moves one edge after the unit goes busy from idle
  assert_fp_total_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(fpu_busy) |-> (fp_issued == $past(fp_issued) + 1'b1));
endmodule

// File: tb/dual_issue_dispatch_tb.sv
module dual_issue_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v0 = 1'b0, v1 = 1'b0;
  logic [1:0]  c0 = 2'd0, c1 = 2'd0;
  logic [1:0]  take_cnt, issue_count, slot0_class, slot1_class;
  logic        stall, fpu_busy, slot0_valid, slot1_valid;
  logic [15:0] total_issued, fp_issued;

  int checks = 0;
  int errors = 0;
  int mcnt = 0;
  int mtotal = 0;
  int mfp = 0;
  int stall_seen = 0;

  always #5 clk = ~clk;

  dual_issue_dispatch u_dut (
    .clk(clk), .rst_n(rst_n),
    .cand0_valid(v0), .cand0_class(c0), .cand1_valid(v1), .cand1_class(c1),
    .take_cnt(take_cnt), .stall(stall), .fpu_busy(fpu_busy),
    .slot0_valid(slot0_valid), .slot0_class(slot0_class),
    .slot1_valid(slot1_valid), .slot1_class(slot1_class),
    .issue_count(issue_count), .total_issued(total_issued), .fp_issued(fp_issued)
  );

  function automatic bit fpc(input logic [1:0] c);
    return (c == 2'd1) || (c == 2'd2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle just after a falling edge and check both the
  // combinational decision and the registered result one edge later.
  task automatic step(input logic a0, input logic [1:0] k0,
                      input logic a1, input logic [1:0] k1);
    int  exp_take;
    bit  exp_stall;
    v0 = a0; c0 = k0; v1 = a1; c1 = k1;
    #1;
    exp_stall = a0 && fpc(k0) && (mcnt != 0);
    if (!a0 || exp_stall) exp_take = 0;
    else exp_take = 1 + ((a1 && !fpc(k1)) ? 1 : 0);
    chk("R5 stall", int'(stall), int'(exp_stall));
    chk("R9 take_cnt (R3/R4/R12/R2)", int'(take_cnt), exp_take);
    if (exp_stall) stall_seen++;
    @(posedge clk);
    if (exp_take >= 1 && fpc(k0)) begin
      mcnt = (k0 == 2'd2) ? 5 : 2;
      mfp++;
    end else if (mcnt > 0) begin
      mcnt--;
    end
    mtotal += exp_take;
    @(negedge clk);
    chk("R9 slot0_valid", int'(slot0_valid), int'(exp_take >= 1));
    chk("R9 slot0_class", int'(slot0_class), (exp_take >= 1) ? int'(k0) : 0);
    chk("R3 slot1_valid", int'(slot1_valid), int'(exp_take == 2));
    chk("R9 slot1_class", int'(slot1_class), (exp_take == 2) ? int'(k1) : 0);
    chk("R9 issue_count", int'(issue_count), exp_take);
    chk("R10 fpu_busy", int'(fpu_busy), int'(mcnt != 0));
    chk("R11 total_issued", int'(total_issued), mtotal & 16'hFFFF);
    chk("R11 fp_issued", int'(fp_issued), mfp & 16'hFFFF);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 1'b0, 2'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state with valid candidates offered
    v0 = 1'b1; v1 = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 take in reset", int'(take_cnt), 0);
    chk("R1 slot0_valid in reset", int'(slot0_valid), 0);
    chk("R1 fpu_busy in reset", int'(fpu_busy), 0);
    chk("R1 totals in reset", int'(total_issued) + int'(fp_issued), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 take in release cycle", int'(take_cnt), 0);
    @(negedge clk);
    #1;
    chk("R1 take after first edge", int'(take_cnt), 0);
    @(negedge clk);
    #1;
    chk("R1 take after synchronizer", int'(take_cnt), 2);
    v0 = 1'b0; v1 = 1'b0;
    @(negedge clk);
    idle(2);

    // R6: register op, two integer pairs, register op again: full rate
    stall_seen = 0;
    for (int r = 0; r < 4; r++) begin
      step(1'b1, 2'd1, 1'b1, 2'd0);
      step(1'b1, 2'd0, 1'b1, 2'd0);
      step(1'b1, 2'd0, 1'b1, 2'd3);
    end
    chk("R6 no stall at 3-cycle spacing", stall_seen, 0);
    idle(3);

    // R7: conversion followed immediately by a register op stalls 5 cycles
    stall_seen = 0;
    step(1'b1, 2'd2, 1'b1, 2'd0);
    for (int i = 0; i < 6; i++) step(1'b1, 2'd1, 1'b1, 2'd0);
    chk("R7 stall cycles after conversion", stall_seen, 5);
    idle(6);

    // R8: integer pairs during a conversion keep full width
    step(1'b1, 2'd2, 1'b0, 2'd0);
    for (int i = 0; i < 4; i++) begin
      v0 = 1'b1; c0 = 2'd0; v1 = 1'b1; c1 = 2'd3;
      #1;
      chk("R8 int pair while busy", int'(take_cnt), 2);
      step(1'b1, 2'd0, 1'b1, 2'd3);
    end
    idle(6);

    // Sweep: every candidate pair against idle / arith-busy / conv-busy / late
    for (int pre = 0; pre < 4; pre++) begin
      for (int a0 = 0; a0 < 2; a0++) begin
        for (int k0 = 0; k0 < 4; k0++) begin
          for (int a1 = 0; a1 < 2; a1++) begin
            for (int k1 = 0; k1 < 4; k1++) begin
              if (pre == 1) step(1'b1, 2'd1, 1'b0, 2'd0);
              if (pre == 2) step(1'b1, 2'd2, 1'b0, 2'd0);
              if (pre == 3) begin
                step(1'b1, 2'd1, 1'b0, 2'd0);
                step(1'b1, 2'd0, 1'b0, 2'd0);
              end
              step(a0[0], k0[1:0], a1[0], k1[1:0]);
              idle(6);
            end
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule